// File: doc/BRIEF.md
# Remote DMA Packet-Memory Port

This block lets a host reach an on-chip packet memory through one auto-incrementing data window instead of a full address map. The host loads a 16-bit start address and a 16-bit byte count, each as a low byte and a high byte. It then writes a command that opens either a remote read or a remote write. From then on, every access to the data window moves one or two bytes, advances the pointer and lowers the remaining count. When the count runs out, the block raises a completion flag in its interrupt status register.

A configuration bit picks byte-wide or word-wide transfers. In word mode, a normal data-window access carries two bytes, and a single trailing byte can be moved with a byte-qualified access. A separate reset port aborts the engine and reports that through its own status flag. The host side is a plain synchronous register bus. Each access lasts one cycle, and read data is valid in the same cycle as the strobe.

Top module: `rdma_port`

## Requirements
- R1: After reset, the status register (offset 0x06) reads 0x80. The address, count, command and configuration registers read 0. No transfer is active, so a data-window read returns 0.
- R2: Offsets 0x02/0x03 hold the start address (low/high byte) and 0x04/0x05 hold the byte count (low/high byte). Bit 0 of offset 0x07 selects word mode. Offset 0x00 holds the last command byte. All of them read back as written.
- R3: A command byte whose bits [5:3] are 001 (read) or 010 (write) and whose bit 1 is set loads the pointer and count from the registers and starts the transfer. The same byte with bit 1 clear starts nothing.
- R4: A command byte with any other value in bits [5:3] ends an active transfer and starts none.
- R5: In byte mode, each access to the data window (offset 0x10) moves one byte through bits [7:0], adds 1 to the pointer and subtracts 1 from the count. Bits [15:8] of read data are 0.
- R6: In word mode, a word access moves the byte at the pointer on bits [7:0] and the next byte on bits [15:8], and lowers the count by 2. An access with the byte qualifier set moves one byte. A word access with one byte left moves only the low lane, and the high lane reads 0.
- R7: When the count reaches zero, the transfer ends and status bit 6 is set. A start command issued with a zero count sets bit 6 at once and starts nothing.
- R8: Writing 1 to status bit 6 or bit 7 clears that bit. Writing 0 leaves it unchanged.
- R9: A data-window read while no transfer is active, or during a remote write, returns 0 and leaves the pointer where it is. A data-window write while idle or during a remote read changes no memory and leaves the pointer where it is.
- R10: A start command issued during an active transfer abandons that transfer. The new one begins from the register values, with a fresh count.
- R11: Any read or write at offset 0x1F aborts the active transfer and sets status bit 7.
- R12: The memory holds 2**MEM_AW bytes, and an address selects its cell modulo that size. As a result, the word-mode window (pages 0x40 to 0x7F) and the byte-mode window (pages 0x20 to 0x3F) alias the same cells, and a transfer wraps past the top of the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Register offset |
| host_byte | input | 1 | Byte-qualified access in word mode |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid in the strobe cycle |

## Verification
On every cycle, the assertions check that an active transfer always has bytes left and that the remaining count only falls between commands. They also check that an idle data window reads 0, that a halt command or a reset-port access leaves the engine stopped, that the write-one-to-clear rule holds, and that the reset state is correct. The bench scenarios are the only way to show that data bytes land in the right cells and come back in lane order. The same goes for the mode-crossing aliasing and wrap past the top of memory, the restart that reloads from the registers, and the exact access on which the completion bit rises.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int XFER_W = 16;
    localparam int REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_ofs_t;

    localparam reg_ofs_t OFS_CMD    = 5'h00;
    localparam reg_ofs_t OFS_SA_LO  = 5'h02;
    localparam reg_ofs_t OFS_SA_HI  = 5'h03;
    localparam reg_ofs_t OFS_CNT_LO = 5'h04;
    localparam reg_ofs_t OFS_CNT_HI = 5'h05;
    localparam reg_ofs_t OFS_ISR    = 5'h06;
    localparam reg_ofs_t OFS_CFG    = 5'h07;
    localparam reg_ofs_t OFS_DATA   = 5'h10;
    localparam reg_ofs_t OFS_RST    = 5'h1F;

    localparam int ISR_DONE_BIT = 6;
    localparam int ISR_RST_BIT  = 7;
    localparam logic [7:0] ISR_INIT = 8'h80;

    localparam int CMD_GO_BIT = 1;
    localparam logic [2:0] OP_FIELD_RD = 3'b001;
    localparam logic [2:0] OP_FIELD_WR = 3'b010;

    typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;

    typedef struct packed {
        logic launch;
        logic halt;
        dir_e dir;
    } cmd_t;

    typedef struct packed {
        logic              active;
        dir_e              dir;
        logic [XFER_W-1:0] ptr;
        logic [XFER_W-1:0] left;
    } xfer_t;

    function automatic cmd_t decode_cmd(input logic [7:0] v);
        cmd_t c;
        c.launch = 1'b0;
        c.halt   = 1'b0;
        c.dir    = DIR_RD;
        if (v[5:3] == OP_FIELD_RD) begin
            c.launch = v[CMD_GO_BIT];
        end else if (v[5:3] == OP_FIELD_WR) begin
            c.launch = v[CMD_GO_BIT];
            c.dir    = DIR_WR;
        end else begin
            c.halt = 1'b1;
        end
        return c;
    endfunction

    function automatic logic [1:0] step_bytes(input logic word_mode,
                                              input logic byte_acc,
                                              input logic [XFER_W-1:0] left);
        if (left == '0)
            return 2'd0;
        if (word_mode && !byte_acc && left >= XFER_W'(2))
            return 2'd2;
        return 2'd1;
    endfunction

endpackage

// File: rtl/rdma_mem.sv
module rdma_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [AW-1:0] a_lo,
    input  logic [AW-1:0] a_hi,
    input  logic [7:0]    d_lo,
    input  logic [7:0]    d_hi,
    output logic [7:0]    q_lo,
    output logic [7:0]    q_hi
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_lo) cells[a_lo] <= d_lo;
        if (we_hi) cells[a_hi] <= d_hi;
    end

    assign q_lo = cells[a_lo];
    assign q_hi = cells[a_hi];
endmodule

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  reg_ofs_t          addr,
    input  logic [7:0]        wbyte,
    input  logic              set_done,
    input  logic              set_rst,
    output logic [XFER_W-1:0] start_addr,
    output logic [XFER_W-1:0] byte_count,
    output logic              word_mode,
    output logic [7:0]        isr,
    output logic              cmd_wr,
    output cmd_t              cmd,
    output logic [7:0]        rd_val
);
    logic [7:0] cmd_q;
    logic [7:0] isr_next;
    logic       wr;

    assign wr     = sel && we;
    assign cmd_wr = wr && (addr == OFS_CMD);
    assign cmd    = decode_cmd(wbyte);

    always_comb begin
        isr_next = isr;
        if (wr && addr == OFS_ISR)
            isr_next = isr & ~wbyte;
        if (set_done) isr_next[ISR_DONE_BIT] = 1'b1;
        if (set_rst)  isr_next[ISR_RST_BIT]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            byte_count <= '0;
            word_mode  <= 1'b0;
            cmd_q      <= '0;
            isr        <= ISR_INIT;
        end else begin
            isr <= isr_next;
            if (wr) begin
                case (addr)
                    OFS_CMD:    cmd_q            <= wbyte;
                    OFS_SA_LO:  start_addr[7:0]  <= wbyte;
                    OFS_SA_HI:  start_addr[15:8] <= wbyte;
                    OFS_CNT_LO: byte_count[7:0]  <= wbyte;
                    OFS_CNT_HI: byte_count[15:8] <= wbyte;
                    OFS_CFG:    word_mode        <= wbyte[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CMD:    rd_val = cmd_q;
            OFS_SA_LO:  rd_val = start_addr[7:0];
            OFS_SA_HI:  rd_val = start_addr[15:8];
            OFS_CNT_LO: rd_val = byte_count[7:0];
            OFS_CNT_HI: rd_val = byte_count[15:8];
            OFS_ISR:    rd_val = isr;
            OFS_CFG:    rd_val = {7'b0, word_mode};
            default:    rd_val = 8'h00;
        endcase
    end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  cmd_t              cmd,
    input  logic [XFER_W-1:0] start_addr,
    input  logic [XFER_W-1:0] byte_count,
    input  logic              word_mode,
    input  logic              win_rd,
    input  logic              win_wr,
    input  logic              byte_acc,
    input  logic              soft_rst,
    output xfer_t             st,
    output logic              take,
    output logic [1:0]        step,
    output logic              fin
);
    always_comb begin
        step = step_bytes(word_mode, byte_acc, st.left);
        take = st.active && ((st.dir == DIR_RD && win_rd) ||
                             (st.dir == DIR_WR && win_wr));
        fin  = (take && st.left == XFER_W'(step)) ||
               (cmd_wr && cmd.launch && byte_count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.active <= 1'b0;
            st.dir    <= DIR_RD;
            st.ptr    <= '0;
            st.left   <= '0;
        end else if (soft_rst) begin
            st.active <= 1'b0;
        end else if (cmd_wr) begin
            if (cmd.halt) begin
                st.active <= 1'b0;
            end else if (cmd.launch) begin
                st.ptr    <= start_addr;
                st.left   <= byte_count;
                st.dir    <= cmd.dir;
                st.active <= (byte_count != '0);
            end
        end else if (take) begin
            st.ptr  <= st.ptr + XFER_W'(step);
            st.left <= st.left - XFER_W'(step);
            if (st.left == XFER_W'(step))
                st.active <= 1'b0;
        end
    end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
    import rdma_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_sel,
    input  logic        host_we,
    input  logic [4:0]  host_addr,
    input  logic        host_byte,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);
    logic [XFER_W-1:0] start_addr;
    logic [XFER_W-1:0] byte_count;
    logic              word_mode;
    logic [7:0]        isr;
    logic              cmd_wr;
    cmd_t              cmd;
    logic [7:0]        rd_val;
    xfer_t             st;
    logic              take;
    logic [1:0]        step;
    logic              fin;
    logic              soft_rst;
    logic              win_hit;
    logic              active;
    logic [XFER_W-1:0] left;
    logic [MEM_AW-1:0] a_lo;
    logic [7:0]        q_lo;
    logic [7:0]        q_hi;
    logic              mem_we;

    assign soft_rst = host_sel && (host_addr == OFS_RST);
    assign win_hit  = host_sel && (host_addr == OFS_DATA);
    assign active   = st.active;
    assign left     = st.left;

    rdma_regs u_regs (
        .clk(clk), .rst(rst), .sel(host_sel), .we(host_we), .addr(host_addr),
        .wbyte(host_wdata[7:0]), .set_done(fin), .set_rst(soft_rst),
        .start_addr(start_addr), .byte_count(byte_count), .word_mode(word_mode),
        .isr(isr), .cmd_wr(cmd_wr), .cmd(cmd), .rd_val(rd_val)
    );

    rdma_engine u_eng (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd(cmd),
        .start_addr(start_addr), .byte_count(byte_count), .word_mode(word_mode),
        .win_rd(win_hit && !host_we), .win_wr(win_hit && host_we),
        .byte_acc(host_byte), .soft_rst(soft_rst),
        .st(st), .take(take), .step(step), .fin(fin)
    );

    assign a_lo   = st.ptr[MEM_AW-1:0];
    assign mem_we = take && (st.dir == DIR_WR);

    rdma_mem #(.AW(MEM_AW)) u_mem (
        .clk(clk), .we_lo(mem_we), .we_hi(mem_we && step == 2'd2),
        .a_lo(a_lo), .a_hi(a_lo + MEM_AW'(1)),
        .d_lo(host_wdata[7:0]), .d_hi(host_wdata[15:8]),
        .q_lo(q_lo), .q_hi(q_hi)
    );

    always_comb begin
        if (!host_sel)
            host_rdata = 16'h0000;
        else if (host_addr == OFS_DATA)
            host_rdata = (take && !host_we) ?
                         {(step == 2'd2) ? q_hi : 8'h00, q_lo} : 16'h0000;
        else
            host_rdata = {8'h00, rd_val};
    end
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk
    import rdma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_sel,
    input logic              host_we,
    input logic [4:0]        host_addr,
    input logic [15:0]       host_wdata,
    input logic [15:0]       host_rdata,
    input logic              active,
    input logic [XFER_W-1:0] left,
    input logic [7:0]        isr
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (isr == ISR_INIT && !active));

    assert_halt_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_we && host_addr == OFS_CMD &&
         host_wdata[5:3] != OP_FIELD_RD && host_wdata[5:3] != OP_FIELD_WR)
        |=> !active);

    assert_count_falls_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !(host_sel && host_we && host_addr == OFS_CMD))
        |=> (left <= $past(left)));

    assert_busy_has_bytes_R7: assert property (@(posedge clk) disable iff (rst)
        active |-> (left != '0));

    assert_done_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_we && host_addr == OFS_ISR && host_wdata[ISR_DONE_BIT])
        |=> !isr[ISR_DONE_BIT]);

    assert_idle_window_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (host_sel && !host_we && host_addr == OFS_DATA && !active)
        |-> (host_rdata == 16'h0000));

    assert_reset_port_R11: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_addr == OFS_RST) |=> (!active && isr[ISR_RST_BIT]));
endmodule

bind rdma_port rdma_port_chk u_chk (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .active(active), .left(left), .isr(isr)
);

// File: tb/sim_rdma_port.sv
`timescale 1ns/1ps
module sim_rdma_port;
    localparam int MEM = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = 5'h0;
    logic        host_byte = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] model [MEM];

    always #4 clk = ~clk;

    rdma_port u0 (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_byte(host_byte), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [4:0] a, input logic bacc,
                       input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        host_sel = 1'b1; host_we = we; host_addr = a; host_byte = bacc; host_wdata = wd;
        #1 rd = host_rdata;
        @(posedge clk);
        #1 host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        logic [15:0] x;
        acc(1'b1, a, 1'b0, {8'h00, d}, x);
    endtask

    task automatic rdr(input logic [4:0] a, output logic [15:0] v);
        acc(1'b0, a, 1'b0, 16'h0000, v);
    endtask

    task automatic setup(input logic mode, input logic [15:0] s, input logic [15:0] n);
        wr(5'h07, {7'b0, mode});
        wr(5'h02, s[7:0]); wr(5'h03, s[15:8]);
        wr(5'h04, n[7:0]); wr(5'h05, n[15:8]);
    endtask

    function automatic logic [7:0] pat(input logic [15:0] s, input int i, input int n);
        return 8'((s[7:0] + i * 13 + n * 7 + 1) & 8'hFF);
    endfunction

    task automatic check_done_clear(input string tag);
        logic [15:0] v;
        rdr(5'h06, v);
        chk(tag, v & 16'h0040, 16'h0040);
        wr(5'h06, 8'h40);
    endtask

    task automatic dma_write(input logic mode, input logic [15:0] s, input int n);
        logic [15:0] d;
        int i;
        setup(mode, s, 16'(n));
        wr(5'h00, 8'h12);
        i = 0;
        while (i < n) begin
            if (mode && (n - i) >= 2) begin
                acc(1'b1, 5'h10, 1'b0, {pat(s, i + 1, n), pat(s, i, n)}, d);
                model[10'(s + 16'(i))]     = pat(s, i, n);
                model[10'(s + 16'(i + 1))] = pat(s, i + 1, n);
                i += 2;
            end else begin
                acc(1'b1, 5'h10, 1'b1, {8'h00, pat(s, i, n)}, d);
                model[10'(s + 16'(i))] = pat(s, i, n);
                i += 1;
            end
        end
        // stray write after the count ran out must be dropped (R9)
        acc(1'b1, 5'h10, 1'b1, 16'h00EE, d);
        check_done_clear("R7 done after remote write");
    endtask

    task automatic dma_read_check(input logic mode, input logic [15:0] s, input int n);
        logic [15:0] d;
        int i;
        setup(mode, s, 16'(n));
        wr(5'h00, 8'h0A);
        i = 0;
        while (i < n) begin
            if (mode && (n - i) >= 2) begin
                acc(1'b0, 5'h10, 1'b0, 16'h0, d);
                chk("R6 word read lanes", d,
                    {model[10'(s + 16'(i + 1))], model[10'(s + 16'(i))]});
                i += 2;
            end else begin
                acc(1'b0, 5'h10, mode, 16'h0, d);
                chk(mode ? "R6 byte-qualified read" : "R5 byte read / R12 alias", d,
                    {8'h00, model[10'(s + 16'(i))]});
                i += 1;
            end
        end
        acc(1'b0, 5'h10, 1'b0, 16'h0, d);
        chk("R9 read past end", d, 16'h0000);
        check_done_clear("R7 done after remote read");
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rdr(5'h06, v); chk("R1 status after reset", v, 16'h0080);
        for (int a = 0; a < 8; a++) begin
            if (a != 6) begin
                rdr(5'(a), v); chk("R1 register zero after reset", v, 16'h0000);
            end
        end
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R1 idle data read", v, 16'h0000);

        // R8 write-one-to-clear
        wr(5'h06, 8'h00); rdr(5'h06, v); chk("R8 zero write keeps bit", v, 16'h0080);
        wr(5'h06, 8'h80); rdr(5'h06, v); chk("R8 one write clears bit", v, 16'h0000);

        // R2 register readback
        setup(1'b1, 16'h5A3C, 16'h0102);
        rdr(5'h02, v); chk("R2 addr low", v, 16'h003C);
        rdr(5'h03, v); chk("R2 addr high", v, 16'h005A);
        rdr(5'h04, v); chk("R2 count low", v, 16'h0002);
        rdr(5'h05, v); chk("R2 count high", v, 16'h0001);
        rdr(5'h07, v); chk("R2 word mode", v, 16'h0001);
        wr(5'h00, 8'h20);
        rdr(5'h00, v); chk("R2 command readback", v, 16'h0020);

        // Fill the whole memory in byte mode (R5)
        setup(1'b0, 16'h2000, 16'(MEM));
        wr(5'h00, 8'h12);
        for (int i = 0; i < MEM; i++) begin
            model[i] = 8'(i ^ 8'h5A);
            acc(1'b1, 5'h10, 1'b0, {8'hFF, 8'(i ^ 8'h5A)}, d);
        end
        check_done_clear("R7 done after fill");

        // Sweep: both modes, lengths 1..9, three start offsets (R5 R6 R12)
        for (int m = 0; m < 2; m++) begin
            for (int n = 1; n <= 9; n++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [15:0] ofs;
                    logic [15:0] wbase;
                    logic [15:0] rbase;
                    ofs   = (k == 0) ? 16'h0100 : (k == 1) ? 16'h01FF : 16'h03FD;
                    wbase = m[0] ? 16'h4000 : 16'h2000;
                    rbase = m[0] ? 16'h2000 : 16'h4000;
                    dma_write(m[0], wbase + ofs, n);
                    dma_read_check(~m[0], rbase + ofs, n + 2);
                end
            end
        end

        // R6 word access with a single byte left, and a 4-byte header fetch
        setup(1'b1, 16'h4500, 16'd3);
        wr(5'h00, 8'h0A);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v);
        chk("R6 first word", v, {model[10'h101], model[10'h100]});
        acc(1'b0, 5'h10, 1'b0, 16'h0, v);
        chk("R6 last byte on low lane only", v, {8'h00, model[10'h102]});
        check_done_clear("R7 done after odd word read");
        dma_read_check(1'b1, 16'h4700, 4);

        // R3 command without start bit
        setup(1'b0, 16'h2100, 16'd4);
        wr(5'h00, 8'h08);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R3 read op without start", v, 16'h0000);
        wr(5'h00, 8'h10);
        acc(1'b1, 5'h10, 1'b0, 16'h0077, v);
        dma_read_check(1'b0, 16'h2100, 2);

        // R4 no-DMA command halts a read
        setup(1'b0, 16'h2200, 16'd8);
        wr(5'h00, 8'h0A);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R4 read before halt", v, {8'h00, model[10'h200]});
        wr(5'h00, 8'h22);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R4 read after halt", v, 16'h0000);
        rdr(5'h06, v); chk("R4 halt does not signal done", v & 16'h0040, 16'h0000);

        // R9 wrong direction during a remote write
        setup(1'b0, 16'h2300, 16'd2);
        wr(5'h00, 8'h12);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R9 read during remote write", v, 16'h0000);
        acc(1'b1, 5'h10, 1'b0, 16'h00A1, v); model[10'h300] = 8'hA1;
        acc(1'b1, 5'h10, 1'b0, 16'h00B2, v); model[10'h301] = 8'hB2;
        check_done_clear("R7 done after two bytes");
        dma_read_check(1'b0, 16'h2300, 2);

        // R10 restart reloads from the registers
        setup(1'b0, 16'h2100, 16'd6);
        wr(5'h00, 8'h0A);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v);
        wr(5'h02, 8'h80); wr(5'h03, 8'h22);
        wr(5'h00, 8'h0A);
        for (int i = 0; i < 5; i++) begin
            acc(1'b0, 5'h10, 1'b0, 16'h0, v);
            chk("R10 restarted stream", v, {8'h00, model[10'(16'h2280 + 16'(i))]});
        end
        rdr(5'h06, v); chk("R10 not done before full fresh count", v & 16'h0040, 16'h0000);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v);
        chk("R10 last byte", v, {8'h00, model[10'h285]});
        check_done_clear("R10 done after fresh count");

        // R7 zero count
        setup(1'b0, 16'h2000, 16'd0);
        wr(5'h00, 8'h0A);
        rdr(5'h06, v); chk("R7 zero count done", v & 16'h0040, 16'h0040);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R7 zero count no transfer", v, 16'h0000);
        wr(5'h06, 8'h40);

        // R11 reset port by write, then by read
        setup(1'b0, 16'h2000, 16'd8);
        wr(5'h00, 8'h0A);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v);
        wr(5'h1F, 8'h00);
        rdr(5'h06, v); chk("R11 reset bit after write", v, 16'h0080);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R11 aborted by write", v, 16'h0000);
        wr(5'h06, 8'h80);
        wr(5'h00, 8'h0A);
        rdr(5'h1F, v);
        rdr(5'h06, v); chk("R11 reset bit after read", v, 16'h0080);
        acc(1'b0, 5'h10, 1'b0, 16'h0, v); chk("R11 aborted by read", v, 16'h0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule